// File: doc/BRIEF.md
# Interlace-Aware Frame Sync Selector

This block sits after a video sync separator whose outputs have already been digitized. It takes a vertical sync pulse and a field parity flag and drives two sync outputs for downstream oscillators, ramps and sequencers. Output B always repeats vertical sync. Output A repeats the field flag while the source is interlaced, because that flag rises exactly once per full frame and so marks the start of a frame. When the source is progressive, the field flag stays high and carries no information. Output A then repeats vertical sync, so neither output is ever stuck at a constant level.

Both inputs pass through two-flop synchronizers. The rising edge of vertical sync is found with a registered compare. On every such edge a three-state machine samples the synchronized field flag. A low sample is proof of an even field. That sends the machine from `ST_PROG` to `ST_INTL` (transition *detect*). In `ST_INTL`, a high sample moves it to `ST_FADE` with the run count at one (transition *fade_start*). In `ST_FADE`, each further high sample adds one to the count. When the count reaches `FADE_CNT`, the machine returns to `ST_PROG` (transition *fade_done*). A low sample in `ST_FADE` returns it to `ST_INTL` (transition *refresh*).

Because the state only changes on a vertical sync edge, output A changes source only at a frame boundary. The source can switch format while running, and no reset is needed. A registered status flag reports the detected format. Each output has its own polarity control, so pulses can be presented positive-going.

Top module: `fsync_frame_sel`

## Requirements
- R1: `vsync_b_o` equals `vsync_i ^ inv_b_i`. A change on `vsync_i` appears on `vsync_b_o` at the third rising clock edge after it is applied (two synchronizer stages plus one output register).
- R2: While `rst_i` (synchronous, active high) is asserted, and after it is released, the machine is in `ST_PROG`: `interlaced_o` is 0 and `frame_a_o` follows vertical sync.
- R3: When the synchronized field flag is sampled low on a rising edge of vertical sync, `interlaced_o` reads 1 from the following clock edge onward.
- R4: While `interlaced_o` is 1, `frame_a_o` equals `field_i ^ inv_a_i`, with the same three-edge latency as R1.
- R5: While `interlaced_o` is 0, `frame_a_o` equals `vsync_i ^ inv_a_i`, with the same three-edge latency as R1.
- R6: From the interlaced state, exactly `FADE_CNT` (default 4) consecutive vertical sync edges with the field flag high return `interlaced_o` to 0. After `FADE_CNT-1` such edges it is still 1.
- R7: A low field sample while the high-run count is below `FADE_CNT` restarts the count from zero.
- R8: Changes of the field flag between vertical sync rising edges do not affect `interlaced_o`, and do not change which source drives `frame_a_o`.
- R9: `inv_a_i` affects only `frame_a_o`, and `inv_b_i` affects only `vsync_b_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset; returns the block to the progressive state |
| vsync_i | input | 1 | Asynchronous vertical sync, active high |
| field_i | input | 1 | Asynchronous field flag: high in the first field, and constantly high for progressive video |
| inv_a_i | input | 1 | 1 inverts output A |
| inv_b_i | input | 1 | 1 inverts output B |
| frame_a_o | output | 1 | Frame start (field flag) when interlaced, otherwise vertical sync |
| vsync_b_o | output | 1 | Vertical sync, always |
| interlaced_o | output | 1 | Registered format flag, 1 = interlaced |

## Verification
A wrong format state shows up at the ports in two ways. `interlaced_o` changes one edge after the vertical sync edge that caused it. Output A then follows the wrong source, and this is visible three edges after any change on the field flag made while vertical sync is low. Errors in the run count appear only at the vertical sync edge that should end the interlaced state: at the fourth consecutive high-field frame, or at a frame where a low sample should have restarted the count. The bench therefore checks the status flag after the third and after the fourth high-field frame, and again after a low sample interrupts the run. A polarity or latency fault is visible on the output three edges after the input changes.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
    typedef enum logic [1:0] {
        ST_PROG = 2'd0,
        ST_INTL = 2'd1,
        ST_FADE = 2'd2
    } fmt_state_t;
endpackage

// File: rtl/fsync_sync2.sv
module fsync_sync2 #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/fsync_edge.sv
module fsync_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) lvl_d <= 1'b0;
        else       lvl_d <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_d;

    // R8
    rise_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);
endmodule

// File: rtl/fsync_fmt_fsm.sv
module fsync_fmt_fsm
    import fsync_pkg::*;
#(
    parameter int FADE_CNT = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rise_i,
    input  logic fld_i,
    output logic intl_o
);
    localparam int CW = $clog2(FADE_CNT + 1);
    localparam logic [CW-1:0] LIM = CW'(FADE_CNT);
    localparam logic [CW-1:0] ONE = CW'(1);

    fmt_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          intl_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_PROG: begin
                if (rise_i && !fld_i) begin
                    state_d = ST_INTL;
                    cnt_d   = '0;
                end
            end
            ST_INTL: begin
                if (rise_i && fld_i) begin
                    if (ONE >= LIM) begin
                        state_d = ST_PROG;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_FADE;
                        cnt_d   = ONE;
                    end
                end
            end
            ST_FADE: begin
                if (rise_i) begin
                    if (!fld_i) begin
                        state_d = ST_INTL;
                        cnt_d   = '0;
                    end else if (cnt_q + ONE >= LIM) begin
                        state_d = ST_PROG;
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_q + ONE;
                    end
                end
            end
            default: begin
                state_d = ST_PROG;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_PROG;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) intl_q <= 1'b0;
        else       intl_q <= (state_d != ST_PROG);
    end

    assign intl_o = intl_q;

    // R8
    state_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rise_i |=> $stable(state_q) && $stable(intl_q));

    // R3
    intl_detect_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_i && !fld_i) |=> intl_q);

    // R5
    prog_stay_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_PROG && !(rise_i && !fld_i)) |=> !intl_q);

    // R6
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < LIM);

    // R7
    refresh_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_FADE && rise_i && !fld_i) |=> (cnt_q == '0));
endmodule

// File: rtl/fsync_out_stage.sv
module fsync_out_stage (
    input  logic clk_i,
    input  logic rst_i,
    input  logic vs_i,
    input  logic fld_i,
    input  logic sel_fld_i,
    input  logic inv_a_i,
    input  logic inv_b_i,
    output logic a_o,
    output logic b_o
);
    logic a_q, b_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= (sel_fld_i ? fld_i : vs_i) ^ inv_a_i;
            b_q <= vs_i ^ inv_b_i;
        end
    end

    assign a_o = a_q;
    assign b_o = b_q;

    // R9
    a_b_link_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !sel_fld_i |=> ((a_q ^ b_q) == $past(inv_a_i ^ inv_b_i)));
endmodule

// File: rtl/fsync_frame_sel.sv
module fsync_frame_sel #(
    parameter int FADE_CNT    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic vsync_i,
    input  logic field_i,
    input  logic inv_a_i,
    input  logic inv_b_i,
    output logic frame_a_o,
    output logic vsync_b_o,
    output logic interlaced_o
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw, synced;
    logic            vs_s, fld_s, vs_rise, intl;

    assign raw = {field_i, vsync_i};

    fsync_sync2 #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw),
        .q_o   (synced)
    );

    assign vs_s  = synced[0];
    assign fld_s = synced[1];

    fsync_edge u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (vs_s),
        .rise_o (vs_rise)
    );

    fsync_fmt_fsm #(.FADE_CNT(FADE_CNT)) u_fsm (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .rise_i (vs_rise),
        .fld_i  (fld_s),
        .intl_o (intl)
    );

    fsync_out_stage u_out (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .vs_i      (vs_s),
        .fld_i     (fld_s),
        .sel_fld_i (intl),
        .inv_a_i   (inv_a_i),
        .inv_b_i   (inv_b_i),
        .a_o       (frame_a_o),
        .b_o       (vsync_b_o)
    );

    assign interlaced_o = intl;

    // R2
    reset_prog_chk: assert property (@(posedge clk_i)
        rst_i |=> !interlaced_o);
endmodule

// File: tb/test_fsync_frame_sel.sv
module test_fsync_frame_sel;
    logic clk = 1'b0;
    logic rst, vsync, field, inv_a, inv_b;
    logic frame_a, vsync_b, intl;
    int   nvec  = 0;
    int   nfail = 0;

    always #2.5 clk = ~clk;

    fsync_frame_sel i_fsync_frame_sel (
        .clk_i        (clk),
        .rst_i        (rst),
        .vsync_i      (vsync),
        .field_i      (field),
        .inv_a_i      (inv_a),
        .inv_b_i      (inv_b),
        .frame_a_o    (frame_a),
        .vsync_b_o    (vsync_b),
        .interlaced_o (intl)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    task automatic frame(input logic f);
        field = f;
        tick(4);
        vsync = 1'b1;
        tick(6);
        vsync = 1'b0;
        tick(6);
    endtask

    task automatic do_reset;
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_reset;
        do_reset();
        check("R2", "status after reset", intl, 1'b0);
        check("R2", "A after reset", frame_a, 1'b0);
        check("R1", "B after reset", vsync_b, 1'b0);
    endtask

    task automatic t_latency;
        vsync = 1'b1;
        tick(2);
        check("R1", "B before third edge", vsync_b, 1'b0);
        tick(1);
        check("R1", "B at third edge", vsync_b, 1'b1);
        check("R5", "A follows vsync", frame_a, 1'b1);
        vsync = 1'b0;
        tick(4);
    endtask

    task automatic t_progressive;
        for (int i = 0; i < 6; i++) frame(1'b1);
        check("R5", "status progressive", intl, 1'b0);
        field = 1'b1;
        vsync = 1'b1;
        tick(4);
        check("R5", "A high in pulse", frame_a, 1'b1);
        vsync = 1'b0;
        tick(4);
        check("R5", "A low after pulse", frame_a, 1'b0);
    endtask

    task automatic t_no_edge_prog;
        field = 1'b0;
        tick(6);
        check("R8", "status w/o vsync edge", intl, 1'b0);
        field = 1'b1;
        tick(4);
        check("R8", "A still vsync", frame_a, 1'b0);
    endtask

    task automatic t_interlace;
        frame(1'b1);
        frame(1'b0);
        check("R3", "status after even field", intl, 1'b1);
        field = 1'b1;
        tick(4);
        check("R4", "A follows field high", frame_a, 1'b1);
        check("R1", "B stays vsync", vsync_b, 1'b0);
        field = 1'b0;
        tick(4);
        check("R4", "A follows field low", frame_a, 1'b0);
        field = 1'b1;
        tick(2);
        field = 1'b0;
        tick(6);
        check("R8", "status kept through field toggles", intl, 1'b1);
    endtask

    task automatic t_fade;
        for (int i = 0; i < 3; i++) frame(1'b1);
        check("R6", "still interlaced after 3 highs", intl, 1'b1);
        frame(1'b1);
        check("R6", "progressive after 4 highs", intl, 1'b0);
        field = 1'b1;
        tick(4);
        check("R5", "A back to vsync", frame_a, 1'b0);
    endtask

    task automatic t_refresh;
        frame(1'b0);
        check("R3", "re-detect", intl, 1'b1);
        for (int i = 0; i < 3; i++) frame(1'b1);
        frame(1'b0);
        for (int i = 0; i < 3; i++) frame(1'b1);
        check("R7", "count restarted", intl, 1'b1);
        frame(1'b1);
        check("R7", "progressive after full run", intl, 1'b0);
    endtask

    task automatic t_invert;
        vsync = 1'b0;
        field = 1'b1;
        inv_a = 1'b1;
        inv_b = 1'b1;
        tick(2);
        check("R9", "A inverted", frame_a, 1'b1);
        check("R9", "B inverted", vsync_b, 1'b1);
        inv_b = 1'b0;
        tick(2);
        check("R9", "A alone inverted", frame_a, 1'b1);
        check("R9", "B not inverted", vsync_b, 1'b0);
        inv_a = 1'b0;
        inv_b = 1'b1;
        tick(2);
        check("R9", "A not inverted", frame_a, 1'b0);
        check("R9", "B alone inverted", vsync_b, 1'b1);
        inv_b = 1'b0;
        tick(2);
    endtask

    task automatic t_reset_mid;
        frame(1'b0);
        check("R3", "interlaced before reset", intl, 1'b1);
        do_reset();
        check("R2", "status cleared by reset", intl, 1'b0);
        field = 1'b1;
        tick(4);
        check("R2", "A follows vsync after reset", frame_a, 1'b0);
    endtask

    initial begin
        rst   = 1'b1;
        vsync = 1'b0;
        field = 1'b1;
        inv_a = 1'b0;
        inv_b = 1'b0;
        t_reset();
        t_latency();
        t_progressive();
        t_no_edge_prog();
        t_interlace();
        t_fade();
        t_refresh();
        t_invert();
        t_reset_mid();
        report();
    end

    initial begin
        #(200000 * 5);
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule